// File: doc/BRIEF.md
# Interval Timer with Comparator

This block keeps a 64-bit time base that advances by one on every clock and shows software a slower view of it: the visible count is the time base divided by four. Software samples the count through a read request and arms a one-shot alarm by writing a 32-bit compare value. The block turns that value into a full 64-bit deadline and raises an interrupt once the time base reaches it.

The compare value is scaled by four and spliced into the low 34 bits of the current time base, so the upper 30 bits come from the present time. If the spliced deadline would fall behind the present time, or less than a minimum lead (1000 ticks by default) ahead of it, the block moves it one full 2^34-tick period later. Software can therefore write a plain 32-bit wrap-around count and still get the next occurrence of that count. The interrupt is sticky until the next write re-arms the comparator. Masking and delivery of the interrupt happen outside this block.

The write port is a valid/ready stream that never applies back-pressure: `wr_ready` is high at all times outside reset, and a write is accepted on every clock edge where `wr_valid` is high. The read response has no ready signal; the requester must take `rd_data` in the cycle `rd_vld` is high.

Top module: `itmr_top`

## Requirements
- R1: After reset the time base equals the parameter `INIT_BASE` and then increases by exactly one on every clock edge.
- R2: A read request sampled at a clock edge yields, after that edge, `rd_vld` high for one cycle and `rd_data` equal to the time base sampled at that edge shifted right by two, with the top two bits zero.
- R3: An accepted write of value W at a time base B forms the deadline {B[63:34], W, 2'b00}.
- R4: If that deadline is less than B plus `LEAD_TICKS`, 2^34 is added to it; the stored deadline is always strictly later than B.
- R5: Once armed, the interrupt goes high after the first clock edge at which the time base is greater than or equal to the deadline, and stays high until the next accepted write.
- R6: The interrupt is low after reset and stays low until a write has armed the comparator; every accepted write clears the interrupt at the edge that accepts it.
- R7: A read and a write at the same edge both use the time base value from before that edge's increment.
- R8: `wr_ready` is high whenever reset is not asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the time base advances on each rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Read request for the visible count |
| rd_data | output | 64 | Visible count (time base divided by four) |
| rd_vld | output | 1 | One-cycle pulse marking a valid `rd_data` |
| wr_valid | input | 1 | Compare value is offered |
| wr_ready | output | 1 | Compare value can be taken (always high out of reset) |
| wr_value | input | 32 | Compare value in visible-count units |
| irq | output | 1 | Alarm interrupt, sticky until the next write |

## Verification
The assertions take for granted that the 64-bit time base never comes within 2^35 ticks of rolling over, so a deadline moved one period ahead is always numerically greater than the present time. The stimulus starts the time base a few thousand ticks below a 2^34 boundary and runs for a few tens of thousands of cycles, far from the top of the 64-bit range, while still crossing the boundary where the splice wraps. Compare values are derived from the live time base plus chosen offsets, so each one lands on a known side of the lead threshold.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int BASE_W   = 64;
  localparam int CMP_W    = 32;
  localparam int SHIFT    = 2;
  localparam int SPLICE_W = CMP_W + SHIFT;
  typedef logic [BASE_W-1:0] base_t;
  typedef logic [CMP_W-1:0]  cmp_t;
endpackage

// File: rtl/itmr_base.sv
module itmr_base
  import itmr_pkg::*;
#(
  parameter base_t INIT_BASE = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  output base_t base_o
);
  base_t base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= INIT_BASE;
    else        base_q <= base_q + base_t'(1);
  end

  assign base_o = base_q;
endmodule

// File: rtl/itmr_readout.sv
module itmr_readout
  import itmr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_req,
  input  base_t base_i,
  output base_t rd_data,
  output logic  rd_vld
);
  base_t data_q;
  logic  vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= rd_req;
      if (rd_req) data_q <= base_i >> SHIFT;
    end
  end

  assign rd_data = data_q;
  assign rd_vld  = vld_q;
endmodule

// File: rtl/itmr_target.sv
module itmr_target
  import itmr_pkg::*;
#(
  parameter int LEAD_TICKS = 1000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_fire,
  input  cmp_t  wr_value,
  input  base_t base_i,
  output base_t target_o,
  output logic  armed_o
);
  localparam base_t PERIOD = base_t'(1) << SPLICE_W;
  localparam base_t LEAD   = base_t'(LEAD_TICKS);

  base_t spliced;
  base_t next_target;
  logic  too_soon;
  base_t target_q;
  logic  armed_q;

  always_comb begin
    spliced     = {base_i[BASE_W-1:SPLICE_W], wr_value, {SHIFT{1'b0}}};
    too_soon    = spliced < (base_i + LEAD);
    next_target = too_soon ? (spliced + PERIOD) : spliced;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      armed_q  <= 1'b0;
    end else if (wr_fire) begin
      target_q <= next_target;
      armed_q  <= 1'b1;
    end
  end

  assign target_o = target_q;
  assign armed_o  = armed_q;
endmodule

// File: rtl/itmr_alarm.sv
module itmr_alarm
  import itmr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_fire,
  input  logic  armed_i,
  input  base_t base_i,
  input  base_t target_i,
  output logic  irq_o
);
  logic irq_q;
  logic reached;

  assign reached = armed_i && (base_i >= target_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (wr_fire) irq_q <= 1'b0;
    else if (reached) irq_q <= 1'b1;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/itmr_top.sv
module itmr_top
  import itmr_pkg::*;
#(
  parameter logic [63:0] INIT_BASE  = 64'd0,
  parameter int          LEAD_TICKS = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_req,
  output logic [63:0] rd_data,
  output logic        rd_vld,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [31:0] wr_value,
  output logic        irq
);
  base_t base_q;
  base_t target_q;
  logic  armed_q;
  logic  wr_fire;

  assign wr_ready = rst_n;
  assign wr_fire  = wr_valid && wr_ready;

  itmr_base #(.INIT_BASE(INIT_BASE)) u_base (
    .clk(clk), .rst_n(rst_n), .base_o(base_q)
  );

  itmr_readout u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .base_i(base_q),
    .rd_data(rd_data), .rd_vld(rd_vld)
  );

  itmr_target #(.LEAD_TICKS(LEAD_TICKS)) u_tgt (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_value(wr_value),
    .base_i(base_q), .target_o(target_q), .armed_o(armed_q)
  );

  itmr_alarm u_alm (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .armed_i(armed_q),
    .base_i(base_q), .target_i(target_q), .irq_o(irq)
  );
endmodule

// File: rtl/itmr_chk.sv
module itmr_chk
  import itmr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic [63:0] rd_data,
  input logic        rd_vld,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic        irq,
  input base_t       base,
  input base_t       target,
  input logic        armed
);
  logic fire;
  assign fire = wr_valid && wr_ready;

  p_base_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> base == $past(base) + base_t'(1));

  p_read_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_vld && rd_data == {2'b00, $past(base[63:2])});

  p_target_ahead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> armed && target > $past(base));

  p_irq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !fire && base >= target |=> irq);

  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !fire |=> irq);

  p_wr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !irq);

  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !irq);

  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);
endmodule

bind itmr_top itmr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_data(rd_data),
  .rd_vld(rd_vld), .wr_valid(wr_valid), .wr_ready(wr_ready), .irq(irq),
  .base(base_q), .target(target_q), .armed(armed_q)
);

// File: tb/sim_itmr_top.sv
module sim_itmr_top;
  localparam int          CLK_NS = 10;
  localparam logic [63:0] INIT   = 64'h4_0000_0000 - 64'd6000;
  localparam logic [63:0] PERIOD = 64'h4_0000_0000;
  localparam int          NV     = 6;

  typedef struct packed {
    logic signed [31:0] off;
    logic               far;
  } vec_t;

  // offset from live time base, and whether the deadline is pushed a period ahead
  localparam vec_t VECS [NV] = '{
    '{32'sd6500, 1'b0},   // crosses the 2^34 boundary: splice wraps, R4 pushes it back
    '{32'sd2000, 1'b0},
    '{32'sd999,  1'b1},   // rounds below the lead: far
    '{-32'sd50,  1'b1},   // already past: far
    '{32'sd1003, 1'b0},   // just beyond the lead
    '{32'sd1500, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_value = '0;
  logic [63:0] rd_data;
  logic        rd_vld;
  logic        wr_ready;
  logic        irq;
  logic [63:0] m;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) m <= INIT;
    else        m <= m + 64'd1;
  end

  itmr_top #(.INIT_BASE(INIT), .LEAD_TICKS(1000)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_data(rd_data),
    .rd_vld(rd_vld), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_value(wr_value), .irq(irq)
  );

  function automatic logic [63:0] exp_target(input logic [63:0] b, input logic [31:0] w);
    logic [63:0] t;
    t = {b[63:34], w, 2'b00};
    if (t < b + 64'd1000) t = t + PERIOD;
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read(input string req);
    logic [63:0] b;
    rd_req = 1'b1;
    b = m;
    tick();
    rd_req = 1'b0;
    chk(rd_vld == 1'b1, req, 64'(rd_vld), 64'd1);
    chk(rd_data == {2'b00, b[63:2]}, req, rd_data, {2'b00, b[63:2]});
  endtask

  task automatic run_vec(input vec_t v, input bit with_read);
    logic [63:0] b, sum, t, delta;
    logic [31:0] w;
    int j;
    bit seen;
    b     = m;
    sum   = b + 64'(v.off);
    w     = sum[33:2];
    t     = exp_target(b, w);
    delta = t - b;
    wr_value = w;
    wr_valid = 1'b1;
    rd_req   = with_read;
    tick();
    wr_valid = 1'b0;
    rd_req   = 1'b0;
    chk(irq == 1'b0, "R6 write clears irq", 64'(irq), 64'd0);
    if (with_read)
      chk(rd_data == {2'b00, b[63:2]}, "R7 same-edge read", rd_data, {2'b00, b[63:2]});
    if (v.far) begin
      seen = 1'b0;
      for (int k = 0; k < 300; k++) begin
        tick();
        if (irq) seen = 1'b1;
      end
      chk(!seen, "R4 deadline pushed one period", 64'(seen), 64'd0);
    end else begin
      j = 0;
      while (!irq && j < 9000) begin
        tick();
        j++;
      end
      chk(64'(j) == delta, "R3 R4 R5 alarm cycle", 64'(j), delta);
      for (int k = 0; k < 20; k++) tick();
      chk(irq == 1'b1, "R5 irq sticky", 64'(irq), 64'd1);
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R6 reset irq", 64'(irq), 64'd0);
    chk(rd_vld == 1'b0, "R2 reset rd_vld", 64'(rd_vld), 64'd0);
    rst_n = 1'b1;
    tick();
    chk(wr_ready == 1'b1, "R8 wr_ready", 64'(wr_ready), 64'd1);
    do_read("R1 R2 first read");
    for (int k = 0; k < 7; k++) tick();
    do_read("R1 R2 later read");
    tick();
    chk(rd_vld == 1'b0, "R2 single pulse", 64'(rd_vld), 64'd0);
    for (int k = 0; k < 40; k++) tick();
    chk(irq == 1'b0, "R6 unarmed irq low", 64'(irq), 64'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i == 1);

    do_read("R1 R2 after boundary");
    chk(wr_ready == 1'b1, "R8 wr_ready later", 64'(wr_ready), 64'd1);

    rst_n = 1'b0;
    tick();
    chk(irq == 1'b0, "R6 irq cleared by reset", 64'(irq), 64'd0);
    rst_n = 1'b1;
    tick();
    do_read("R1 base restarts at INIT_BASE");
    chk(m - INIT < 64'd8, "R1 model restart", m - INIT, 64'd2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule